// File: doc/BRIEF.md
# Nine-bit serial frame transmitter

This block sends one asynchronous frame of eleven bits each time a byte is written to it. A frame opens with a low start bit. The eight data bits follow, least significant bit first. A ninth bit, set by a separate input at the moment of the write, comes next. A high stop bit closes the frame. When no frame is in progress the line rests high.

Bit timing comes from a free-running chain that the transmit path never resets. A prescaler makes a tick at sixteen times the baud rate: every 4 clocks in normal mode, or every 2 clocks in double-rate mode. That gives a baud rate of 1/64 or 1/32 of the clock. A divide-by-16 slice counter advances on each tick, and its rollover marks every bit boundary. A write is therefore not sent at once. It waits for the next rollover, which can take up to one bit time.

When the stop bit goes out, the block sets a sticky done flag. Software clears the flag through a clear input. A write that arrives while a frame is in progress is dropped.

Top module: `nine_bit_tx`

States of the frame controller:
- `ST_IDLE`: the line is high and a write is accepted. A write moves to `ST_ARMED`.
- `ST_ARMED`: waiting for the first rollover. On the rollover the start bit is driven and the state moves to `ST_SHIFT`.
- `ST_SHIFT`: one bit is driven per rollover. On the rollover that drives the stop bit the done flag is set and the state returns to `ST_IDLE`.

## Requirements
- R1: After reset `txd_o` is 1 and `done_o` is 0. `txd_o` is 1 whenever no frame is in progress.
- R2: With `baud_fast_i`=0 the prescaler ticks every 4 clocks, so one bit lasts 64 clocks. With `baud_fast_i`=1 it ticks every 2 clocks, so one bit lasts 32 clocks. A prescaler count at or above the current limit ticks and wraps to 0.
- R3: The slice counter runs freely from reset. It rolls over once every 16 ticks, and writes never reset it.
- R4: A write is accepted only in `ST_IDLE`. The start bit (0) appears on `txd_o` one clock after the first rollover that comes strictly after the write cycle.
- R5: The data bits are driven least significant bit first. Each bit changes `txd_o` one clock after the next rollover, and `txd_o` changes at no other time.
- R6: The value of `ninth_i` in the write cycle is sent after data bit 7 and before the stop bit.
- R7: The stop bit (1) is driven one clock after the 11th rollover following the write. `done_o` rises in that same clock.
- R8: `done_o` stays 1 until a cycle with `done_clr_i`=1 clears it. If the clear comes in the same cycle as the set, the set wins.
- R9: A write while a frame is in progress (`ST_ARMED` or `ST_SHIFT`) has no effect on the frame being sent.
- R10: A write accepted right after the stop bit starts a new frame at the following rollover. The earlier stop bit therefore lasts at least one full bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_fast_i | input | 1 | 1 selects clock/32, 0 selects clock/64 |
| wr_en_i | input | 1 | Write strobe for the transmit byte |
| wr_data_i | input | 8 | Byte to send |
| ninth_i | input | 1 | Ninth bit, captured with the write |
| done_clr_i | input | 1 | Clears the done flag |
| txd_o | output | 1 | Serial output |
| done_o | output | 1 | Sticky transmit-done flag |

## Verification
The hardest cases are the ones that depend on where a write or a clear lands relative to the free-running rollover. A write in the same cycle as a rollover must wait a full extra bit. A clear that meets the set of the done flag must lose. The stimulus sweeps the write offset through many clock positions inside the slice period. It also holds the clear input high across the end of a frame, so a clear is present in the exact cycle the flag is set. A behavioural reference model of the prescaler, the slice counter and a bit queue is compared against the outputs on every clock. Any timing slip therefore shows up in the cycle it happens.

// File: rtl/ntx_pkg.sv
package ntx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ntx_prescaler.sv
module ntx_prescaler #(
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fast_i,
    output logic tick_o
);
    localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit  = fast_i ? FAST_LIM : SLOW_LIM;
    assign tick_o = (cnt_q >= limit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/ntx_slice_counter.sv
module ntx_slice_counter #(
    parameter int SLICES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic roll_o
);
    localparam int SW = $clog2(SLICES);
    localparam logic [SW-1:0] LAST = SW'(SLICES - 1);

    logic [SW-1:0] slice_q;

    assign roll_o = tick_i && (slice_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slice_q <= '0;
        end else if (tick_i) begin
            slice_q <= roll_o ? '0 : slice_q + SW'(1);
        end
    end
endmodule

// File: rtl/ntx_frame_fsm.sv
module ntx_frame_fsm
    import ntx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              roll_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ninth_i,
    input  logic              done_clr_i,
    output logic              txd_o,
    output logic              done_o,
    output tx_state_e         state_o,
    output logic              last_bit_o,
    output logic [DATA_W+2:0] frame_o
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int BW      = $clog2(FRAME_W + 1);

    tx_state_e          state_q, state_d;
    logic [FRAME_W-1:0] frame_q;
    logic [BW-1:0]      left_q;
    logic               accept;
    logic               drive;

    assign accept     = (state_q == ST_IDLE) && wr_en_i;
    assign drive      = roll_i && (state_q != ST_IDLE);
    assign last_bit_o = roll_i && (state_q == ST_SHIFT) && (left_q == BW'(1));
    assign state_o    = state_q;
    assign frame_o    = frame_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_en_i)    state_d = ST_ARMED;
            ST_ARMED: if (roll_i)     state_d = ST_SHIFT;
            ST_SHIFT: if (last_bit_o) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame shifter, line driver and done flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frame_q <= '1;
            left_q  <= '0;
            txd_o   <= 1'b1;
            done_o  <= 1'b0;
        end else begin
            if (accept) begin
                frame_q <= {1'b1, ninth_i, wr_data_i, 1'b0};
                left_q  <= BW'(FRAME_W);
            end else if (drive) begin
                txd_o   <= frame_q[0];
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                left_q  <= left_q - BW'(1);
            end
            if (last_bit_o) begin
                done_o <= 1'b1;
            end else if (done_clr_i) begin
                done_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nine_bit_tx.sv
module nine_bit_tx
    import ntx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLICES   = 16,
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              baud_fast_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ninth_i,
    input  logic              done_clr_i,
    output logic              txd_o,
    output logic              done_o
);
    logic              tick;
    logic              roll;
    logic              last_bit;
    tx_state_e         state;
    logic [DATA_W+2:0] frame;

    ntx_prescaler #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fast_i (baud_fast_i),
        .tick_o (tick)
    );

    ntx_slice_counter #(
        .SLICES (SLICES)
    ) u_slice (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .roll_o (roll)
    );

    ntx_frame_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .roll_i     (roll),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .ninth_i    (ninth_i),
        .done_clr_i (done_clr_i),
        .txd_o      (txd_o),
        .done_o     (done_o),
        .state_o    (state),
        .last_bit_o (last_bit),
        .frame_o    (frame)
    );
endmodule

// File: rtl/ntx_checker.sv
module ntx_checker
    import ntx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fast,
    input logic              tick,
    input logic              roll,
    input logic              wr_en,
    input logic              clr,
    input logic              txd,
    input logic              done,
    input logic              last_bit,
    input tx_state_e         state,
    input logic [DATA_W+2:0] frame
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> txd); // R1

    AST_FAST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && !tick) |=> (tick || !fast)); // R2

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && roll) |=> !txd); // R4

    AST_LINE_MOVES_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(txd)); // R5

    AST_STOP_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |=> (txd && done && state == ST_IDLE)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !last_bit) |=> !done); // R8

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state != ST_IDLE && !roll) |=> $stable(frame)); // R9
endmodule

bind nine_bit_tx ntx_checker #(.DATA_W(DATA_W)) u_ntx_checker (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .fast     (baud_fast_i),
    .tick     (tick),
    .roll     (roll),
    .wr_en    (wr_en_i),
    .clr      (done_clr_i),
    .txd      (txd_o),
    .done     (done_o),
    .last_bit (last_bit),
    .state    (state),
    .frame    (frame)
);

// File: tb/test_nine_bit_tx.sv
`timescale 1ns/1ps
module test_nine_bit_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] data = 8'h00;
    logic       ninth = 1'b0;
    logic       clr = 1'b0;
    logic       txd;
    logic       done;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    nine_bit_tx i_nine_bit_tx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .baud_fast_i (fast),
        .wr_en_i     (wr),
        .wr_data_i   (data),
        .ninth_i     (ninth),
        .done_clr_i  (clr),
        .txd_o       (txd),
        .done_o      (done)
    );

    // Behavioural reference model
    int m_pre = 0;
    int m_slice = 0;
    int m_state = 0;
    bit m_txd = 1'b1;
    bit m_done = 1'b0;
    bit m_bits[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_slice = 0; m_state = 0;
            m_txd = 1'b1; m_done = 1'b0; m_bits.delete();
        end else begin
            int  per;
            bit  tk;
            bit  rl;
            bit  set_done;
            per = fast ? 2 : 4;
            tk = (m_pre >= per - 1);
            rl = tk && (m_slice == 15);
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) m_slice = (m_slice + 1) % 16;
            set_done = 1'b0;
            case (m_state)
                0: if (wr) begin
                    m_bits.delete();
                    m_bits.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_bits.push_back(data[i]);
                    m_bits.push_back(ninth);
                    m_bits.push_back(1'b1);
                    m_state = 1;
                end
                1: if (rl) begin
                    m_txd = m_bits.pop_front();
                    m_state = 2;
                end
                default: if (rl) begin
                    m_txd = m_bits.pop_front();
                    if (m_bits.size() == 0) begin
                        set_done = 1'b1;
                        m_state = 0;
                    end
                end
            endcase
            if (set_done) m_done = 1'b1;
            else if (clr) m_done = 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk({phase, " txd"}, int'(txd), int'(m_txd));
            chk({phase, " done"}, int'(done), int'(m_done));
        end
    end

    task automatic send(input logic [7:0] d, input logic n);
        @(negedge clk);
        wr = 1'b1; data = d; ninth = n;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic clear_done();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk("R1 idle txd", int'(txd), 1);

        // R2, R4, R5, R6, R7: slow frame and bit length
        phase = "R5 R6 slow frame";
        send(8'hA5, 1'b1);
        while (txd) @(negedge clk);
        t0 = cyc;
        wait_done();
        chk("R2 R7 slow start-to-done clocks", cyc - t0, 640);

        // R8: flag sticky until cleared
        phase = "R8 sticky";
        repeat (50) @(negedge clk);
        chk("R8 done held", int'(done), 1);
        clear_done();
        chk("R8 done cleared", int'(done), 0);

        // R2: fast rate
        phase = "R2 fast frame";
        fast = 1'b1;
        repeat (37) @(negedge clk);
        send(8'h3C, 1'b0);
        while (txd) @(negedge clk);
        t0 = cyc;
        wait_done();
        chk("R2 fast start-to-done clocks", cyc - t0, 320);
        clear_done();

        // R9: write during a frame is dropped
        phase = "R9 busy write";
        send(8'h81, 1'b0);
        repeat (5) @(negedge clk);
        send(8'hFF, 1'b1);
        repeat (200) @(negedge clk);
        send(8'h00, 1'b1);
        wait_done();
        clear_done();

        // R8: clear held across the set
        phase = "R8 clear meets set";
        clr = 1'b1;
        send(8'h5A, 1'b1);
        wait_done();
        chk("R8 set wins over clear", int'(done), 1);
        @(negedge clk);
        chk("R8 clear after set", int'(done), 0);
        clr = 1'b0;

        // R10: back-to-back frames
        phase = "R10 back to back";
        send(8'h01, 1'b0);
        wait_done();
        send(8'hFE, 1'b1);
        clear_done();
        wait_done();
        clear_done();

        // R3, R4: writes at many offsets in the slice period, both rates
        for (int k = 0; k < 12; k++) begin
            phase = "R3 R4 offset sweep";
            fast = k[0];
            repeat (k * 3 + 1) @(negedge clk);
            send(8'(k * 37 + 11), k[1]);
            wait_done();
            clear_done();
        end

        phase = "R1 final idle";
        repeat (150) @(negedge clk);
        chk("R1 final txd", int'(txd), 1);
        finish_up();
    end
endmodule